// File: doc/BRIEF.md
# Multi-Stream Sequential Data Prefetcher

The block watches the stream of first-level data-cache misses and demand hits, each tagged with an address and a thread number. It finds sequential access patterns and sends prefetch requests ahead of the program, so that later demand accesses find their lines already present. Sixteen stream trackers are split evenly between two threads. A thread only matches against, allocates into and replaces its own trackers. Every miss also sends an unconditional next-line request to the second-level cache.

A tracker is created on a miss, with no confirmation step first. The next access to a line next to its head fixes the direction: one line higher means ascending, one line lower means descending. After that, each access to the next line in that direction advances the tracker. An advance sends a first-level prefetch a fixed two lines ahead and a second-level prefetch at the tracker's current distance. That distance starts at three lines and grows by one on each advance, up to a ceiling that software writes. The upper limit on that ceiling is 24 lines. Requests leave on three registered channels: next-line, first-level stream and second-level stream. Each request appears one cycle after the access that caused it and carries a 128-byte line address.

Top module: `pf_stream_engine`

## Requirements
- R1: After reset, no request channel is valid and the distance ceiling is 24 lines.
- R2: Every miss produces, in the following cycle, a next-line request for the line after the missed line. A demand hit never produces one.
- R3: A miss that matches no tracker of its thread claims that thread's lowest-numbered idle tracker. The tracker's head is the missed line and its distance is 3. The miss produces no stream request.
- R4: An access by the owning thread to the line just above or just below the head of an undirected tracker sets its direction to ascending or descending, and advances it.
- R5: An advance moves the head to the accessed line. In the following cycle it issues, together, a first-level request 2 lines past the new head and a second-level request at the new distance past the head, both in the tracker's direction.
- R6: Each advance raises the distance by one, but never above the current ceiling.
- R7: A ceiling write below 3 stores 3, a write above 24 stores 24, and any other value is stored as written. A lower ceiling pulls a larger distance down to the ceiling at that tracker's next advance.
- R8: Thread 0 owns trackers 0 to 7 and thread 1 owns trackers 8 to 15. An access never matches, advances or replaces a tracker of the other thread.
- R9: A miss that matches nothing while all of its thread's trackers are busy replaces that thread's least recently used tracker. A tracker counts as used when it is claimed or advanced.
- R10: A directed tracker advances only on the next line in its direction. Any other hit, including a repeat of the head or a step backwards, produces no request.
- R11: When a miss and a hit arrive in the same cycle, the miss is handled and the hit is discarded.
- R12: Address bits 6 to 0 select a byte inside a 128-byte line and do not affect matching. All request addresses have those bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | First-level data miss this cycle |
| miss_addr_i | input | 48 | Byte address of the miss |
| miss_tid_i | input | 1 | Thread of the miss |
| hit_valid_i | input | 1 | Demand hit this cycle |
| hit_addr_i | input | 48 | Byte address of the hit |
| hit_tid_i | input | 1 | Thread of the hit |
| depth_we_i | input | 1 | Write strobe for the distance ceiling |
| depth_wdata_i | input | 5 | New distance ceiling in lines |
| pf_nl_valid_o | output | 1 | Next-line second-level request valid |
| pf_nl_addr_o | output | 48 | Next-line request address |
| pf_l1_valid_o | output | 1 | First-level stream request valid |
| pf_l1_addr_o | output | 48 | First-level stream request address |
| pf_l2_valid_o | output | 1 | Second-level stream request valid |
| pf_l2_addr_o | output | 48 | Second-level stream request address |

## Verification
The hardest state to reach from the ports is replacement. It needs all eight of one thread's trackers busy, with a recency order known exactly. The stimulus gets there by letting one tracker run a long ascending stream, then claiming the other seven with misses to distant lines. An access next to the old stream then shows whether that tracker was evicted. The ceiling clamp needs more than twenty consecutive advances on one tracker before the distance reaches 24. Same-cycle miss-and-hit collisions are driven on purpose, and each is followed by a lone hit that reveals whether the discarded hit had moved any tracker.

// File: rtl/pf_pkg.sv
package pf_pkg;
  parameter int ADDR_W     = 48;
  parameter int LINE_OFF   = 7;
  parameter int DEPTH_MAX  = 24;
  parameter int DEPTH_INIT = 3;
  parameter int L1_DIST    = 2;
  localparam int LINE_W    = ADDR_W - LINE_OFF;
  localparam int DEPTH_W   = $clog2(DEPTH_MAX + 2);

  typedef logic [LINE_W-1:0]  line_t;
  typedef logic [DEPTH_W-1:0] depth_t;

  typedef struct packed {
    logic   vld;
    logic   conf;   // direction known
    logic   desc;
    line_t  head;
    depth_t depth;
  } stream_t;
endpackage

// File: rtl/pf_match.sv
module pf_match
  import pf_pkg::*;
#(
  parameter int NUM_STREAMS = 16,
  parameter int PER_THREAD  = 8,
  parameter int TID_W       = 1
) (
  input  stream_t                 strm_i [NUM_STREAMS],
  input  logic [TID_W-1:0]        tid_i,
  input  line_t                   line_i,
  output logic [NUM_STREAMS-1:0]  hit_o,
  output logic [NUM_STREAMS-1:0]  desc_o,
  output logic [NUM_STREAMS-1:0]  free_o
);
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_ent
    localparam int OWNER = g / PER_THREAD;
    line_t up, dn;
    logic  own;
    assign up  = strm_i[g].head + 1'b1;
    assign dn  = strm_i[g].head - 1'b1;
    assign own = (OWNER == int'(tid_i));
    assign hit_o[g] = strm_i[g].vld && own &&
                      (strm_i[g].conf ? (strm_i[g].desc ? (line_i == dn) : (line_i == up))
                                      : ((line_i == up) || (line_i == dn)));
    assign desc_o[g] = strm_i[g].conf ? strm_i[g].desc : (line_i == dn);
    assign free_o[g] = own && !strm_i[g].vld;
  end
endmodule

// File: rtl/pf_lru.sv
module pf_lru #(
  parameter int NUM_STREAMS = 16,
  parameter int PER_THREAD  = 8,
  parameter int TID_W       = 1,
  parameter int IDX_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [TID_W-1:0] tid_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam int AGE_W = (PER_THREAD > 1) ? $clog2(PER_THREAD) : 1;

  // per-thread recency rank, 0 = newest, PER_THREAD-1 = oldest
  logic [AGE_W-1:0] age_q [NUM_STREAMS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_STREAMS; i++) age_q[i] <= AGE_W'(i % PER_THREAD);
    end else if (touch_i) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        if ((i / PER_THREAD) == (int'(touch_idx_i) / PER_THREAD)) begin
          if (i == int'(touch_idx_i)) age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < NUM_STREAMS; i++) begin
      if ((i / PER_THREAD) == int'(tid_i) && age_q[i] == AGE_W'(PER_THREAD - 1))
        victim_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pf_stream_engine.sv
module pf_stream_engine
  import pf_pkg::*;
#(
  parameter int NUM_THREADS  = 2,
  parameter int PER_THREAD   = 8,
  localparam int NUM_STREAMS = NUM_THREADS * PER_THREAD,
  localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W       = $clog2(NUM_STREAMS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [TID_W-1:0]  miss_tid_i,
  input  logic              hit_valid_i,
  input  logic [ADDR_W-1:0] hit_addr_i,
  input  logic [TID_W-1:0]  hit_tid_i,
  input  logic              depth_we_i,
  input  logic [DEPTH_W-1:0] depth_wdata_i,
  output logic              pf_nl_valid_o,
  output logic [ADDR_W-1:0] pf_nl_addr_o,
  output logic              pf_l1_valid_o,
  output logic [ADDR_W-1:0] pf_l1_addr_o,
  output logic              pf_l2_valid_o,
  output logic [ADDR_W-1:0] pf_l2_addr_o
);
  stream_t strm_q [NUM_STREAMS];
  depth_t  depth_max_q;

  logic             evt_v;
  logic [TID_W-1:0] evt_tid;
  line_t            evt_line;
  logic             unused_offsets;

  assign evt_v    = miss_valid_i || hit_valid_i;
  assign evt_tid  = miss_valid_i ? miss_tid_i : hit_tid_i;
  assign evt_line = miss_valid_i ? miss_addr_i[ADDR_W-1:LINE_OFF] : hit_addr_i[ADDR_W-1:LINE_OFF];
  assign unused_offsets = ^{miss_addr_i[LINE_OFF-1:0], hit_addr_i[LINE_OFF-1:0]};

  logic [NUM_STREAMS-1:0] hit_vec, desc_vec, free_vec;

  pf_match #(
    .NUM_STREAMS(NUM_STREAMS), .PER_THREAD(PER_THREAD), .TID_W(TID_W)
  ) u_match (
    .strm_i (strm_q),
    .tid_i  (evt_tid),
    .line_i (evt_line),
    .hit_o  (hit_vec),
    .desc_o (desc_vec),
    .free_o (free_vec)
  );

  // lowest index wins
  logic             match_any, free_any;
  logic [IDX_W-1:0] match_idx, free_idx;
  always_comb begin
    match_any = 1'b0; match_idx = '0;
    free_any  = 1'b0; free_idx  = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (hit_vec[i])  begin match_any = 1'b1; match_idx = IDX_W'(i); end
      if (free_vec[i]) begin free_any  = 1'b1; free_idx  = IDX_W'(i); end
    end
  end

  logic             adv, alloc, touch;
  logic [IDX_W-1:0] victim_idx, alloc_idx, touch_idx;

  assign adv       = evt_v && match_any;
  assign alloc     = miss_valid_i && !match_any;
  assign alloc_idx = free_any ? free_idx : victim_idx;
  assign touch     = adv || alloc;
  assign touch_idx = adv ? match_idx : alloc_idx;

  pf_lru #(
    .NUM_STREAMS(NUM_STREAMS), .PER_THREAD(PER_THREAD), .TID_W(TID_W), .IDX_W(IDX_W)
  ) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .tid_i       (evt_tid),
    .victim_o    (victim_idx)
  );

  depth_t nxt_depth;
  logic   sel_desc;
  line_t  l1_line, l2_line;

  assign sel_desc  = desc_vec[match_idx];
  assign nxt_depth = (strm_q[match_idx].depth >= depth_max_q) ? depth_max_q
                                                              : strm_q[match_idx].depth + 1'b1;
  assign l1_line   = sel_desc ? evt_line - line_t'(L1_DIST) : evt_line + line_t'(L1_DIST);
  assign l2_line   = sel_desc ? evt_line - line_t'(nxt_depth) : evt_line + line_t'(nxt_depth);

  function automatic depth_t clamp_depth(depth_t v);
    if (v < depth_t'(DEPTH_INIT)) return depth_t'(DEPTH_INIT);
    if (v > depth_t'(DEPTH_MAX))  return depth_t'(DEPTH_MAX);
    return v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_STREAMS; i++) strm_q[i] <= '0;
      depth_max_q   <= depth_t'(DEPTH_MAX);
      pf_nl_valid_o <= 1'b0;
      pf_nl_addr_o  <= '0;
      pf_l1_valid_o <= 1'b0;
      pf_l1_addr_o  <= '0;
      pf_l2_valid_o <= 1'b0;
      pf_l2_addr_o  <= '0;
    end else begin
      if (adv) begin
        strm_q[match_idx].conf  <= 1'b1;
        strm_q[match_idx].desc  <= sel_desc;
        strm_q[match_idx].head  <= evt_line;
        strm_q[match_idx].depth <= nxt_depth;
      end else if (alloc) begin
        strm_q[alloc_idx] <= '{vld: 1'b1, conf: 1'b0, desc: 1'b0,
                               head: evt_line, depth: depth_t'(DEPTH_INIT)};
      end
      if (depth_we_i) depth_max_q <= clamp_depth(depth_wdata_i);

      pf_nl_valid_o <= miss_valid_i;
      pf_nl_addr_o  <= {evt_line + 1'b1, {LINE_OFF{1'b0}}};
      pf_l1_valid_o <= adv;
      pf_l1_addr_o  <= {l1_line, {LINE_OFF{1'b0}}};
      pf_l2_valid_o <= adv;
      pf_l2_addr_o  <= {l2_line, {LINE_OFF{1'b0}}};
    end
  end
endmodule

// File: rtl/pf_stream_engine_chk.sv
module pf_stream_engine_chk
  import pf_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic [ADDR_W-1:0] miss_addr_i,
  input logic              hit_valid_i,
  input logic              pf_nl_valid_o,
  input logic [ADDR_W-1:0] pf_nl_addr_o,
  input logic              pf_l1_valid_o,
  input logic [ADDR_W-1:0] pf_l1_addr_o,
  input logic              pf_l2_valid_o,
  input logic [ADDR_W-1:0] pf_l2_addr_o,
  input depth_t            depth_max_q
);
  assert_nl_follows_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> pf_nl_valid_o &&
      (pf_nl_addr_o[ADDR_W-1:LINE_OFF] == $past(miss_addr_i[ADDR_W-1:LINE_OFF]) + 1'b1));

  assert_no_nl_without_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> !pf_nl_valid_o);

  assert_stream_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_l1_valid_o == pf_l2_valid_o);

  assert_l2_beyond_l1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_l1_valid_o |-> pf_l1_addr_o != pf_l2_addr_o);

  assert_idle_no_stream_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_valid_i && !hit_valid_i) |=> !pf_l1_valid_o);

  assert_ceiling_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_max_q >= depth_t'(DEPTH_INIT) && depth_max_q <= depth_t'(DEPTH_MAX));
endmodule

bind pf_stream_engine pf_stream_engine_chk i_chk (.*);

// File: tb/test_pf_stream_engine.sv
module test_pf_stream_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_v = 1'b0, hit_v = 1'b0, we = 1'b0;
  logic [47:0] miss_a = '0, hit_a = '0;
  logic        miss_t = 1'b0, hit_t = 1'b0;
  logic [4:0]  wd = '0;
  logic        nl_v, l1_v, l2_v;
  logic [47:0] nl_a, l1_a, l2_a;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pf_stream_engine i_pf_stream_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_v), .miss_addr_i(miss_a), .miss_tid_i(miss_t),
    .hit_valid_i(hit_v), .hit_addr_i(hit_a), .hit_tid_i(hit_t),
    .depth_we_i(we), .depth_wdata_i(wd),
    .pf_nl_valid_o(nl_v), .pf_nl_addr_o(nl_a),
    .pf_l1_valid_o(l1_v), .pf_l1_addr_o(l1_a),
    .pf_l2_valid_o(l2_v), .pf_l2_addr_o(l2_a)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";

  // behavioural reference
  bit          m_vld [16], m_conf [16], m_desc [16];
  logic [40:0] m_head [16];
  int          m_depth [16], m_stamp [16];
  int          now_stamp = 0, m_max = 24;
  bit          e_nl_v, e_l1_v, e_l2_v;
  logic [47:0] e_nl, e_l1, e_l2;

  function automatic logic [47:0] la(logic [40:0] ln);
    return {ln, 7'b0};
  endfunction

  task automatic chk_chan(string nm, logic v, logic [47:0] a, bit ev, logic [47:0] ea);
    checks++;
    if (v !== ev || (ev && a !== ea)) begin
      errors++;
      $display("FAIL %s %s: actual v=%0b a=%h expected v=%0b a=%h", cur_req, nm, v, a, ev, ea);
    end
  endtask

  task automatic model(bit mv, logic [47:0] ma, bit mt, bit hv, logic [47:0] ha, bit ht,
                       bit w, int d);
    e_nl_v = 0; e_l1_v = 0; e_l2_v = 0;
    if (mv || hv) begin
      bit          tid = mv ? mt : ht;
      logic [40:0] ln  = mv ? ma[47:7] : ha[47:7];
      int          j   = -1;
      if (mv) begin e_nl_v = 1; e_nl = la(ln + 1); end
      for (int i = 15; i >= 0; i--) begin
        if (m_vld[i] && (i / 8) == int'(tid)) begin
          if (m_conf[i] ? (m_desc[i] ? ln == m_head[i] - 1 : ln == m_head[i] + 1)
                        : (ln == m_head[i] + 1 || ln == m_head[i] - 1)) j = i;
        end
      end
      if (j >= 0) begin
        int nd = (m_depth[j] >= m_max) ? m_max : m_depth[j] + 1;
        bit ds = m_conf[j] ? m_desc[j] : (ln == m_head[j] - 1);
        m_conf[j] = 1; m_desc[j] = ds; m_head[j] = ln; m_depth[j] = nd;
        e_l1_v = 1; e_l2_v = 1;
        e_l1 = la(ds ? ln - 2 : ln + 2);
        e_l2 = la(ds ? ln - 41'(nd) : ln + 41'(nd));
        now_stamp++; m_stamp[j] = now_stamp;
      end else if (mv) begin
        int k = -1;
        for (int i = 8 * int'(tid) + 7; i >= 8 * int'(tid); i--) if (!m_vld[i]) k = i;
        if (k < 0) begin
          k = 8 * int'(tid);
          for (int i = 8 * int'(tid); i < 8 * int'(tid) + 8; i++)
            if (m_stamp[i] < m_stamp[k]) k = i;
        end
        m_vld[k] = 1; m_conf[k] = 0; m_desc[k] = 0; m_head[k] = ln; m_depth[k] = 3;
        now_stamp++; m_stamp[k] = now_stamp;
      end
    end
    if (w) m_max = (d < 3) ? 3 : (d > 24) ? 24 : d;
  endtask

  task automatic step(bit mv, logic [47:0] ma, bit mt, bit hv, logic [47:0] ha, bit ht,
                      bit w = 0, int d = 0);
    @(negedge clk);
    chk_chan("nl", nl_v, nl_a, e_nl_v, e_nl);
    chk_chan("l1", l1_v, l1_a, e_l1_v, e_l1);
    chk_chan("l2", l2_v, l2_a, e_l2_v, e_l2);
    miss_v = mv; miss_a = ma; miss_t = mt;
    hit_v = hv; hit_a = ha; hit_t = ht; we = w; wd = 5'(d);
    model(mv, ma, mt, hv, ha, ht, w, d);
  endtask

  task automatic miss(logic [40:0] ln, bit t, logic [6:0] off = 0);
    step(1, {ln, off}, t, 0, '0, 0);
  endtask
  task automatic hit(logic [40:0] ln, bit t, logic [6:0] off = 0);
    step(0, '0, 0, 1, {ln, off}, t);
  endtask
  task automatic idle();
    step(0, '0, 0, 0, '0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 0; m_conf[i] = 0; m_desc[i] = 0; m_head[i] = '0;
      m_depth[i] = 0; m_stamp[i] = -(i % 8);
    end
    e_nl_v = 0; e_l1_v = 0; e_l2_v = 0; e_nl = '0; e_l1 = '0; e_l2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(); idle();
    cur_req = "R3"; miss(41'd100, 0);                 // claims tracker 0
    cur_req = "R4"; miss(41'd101, 0, 7'h45);           // ascending, advance
    cur_req = "R6";
    for (int i = 102; i <= 125; i++) hit(41'(i), 0, 7'(i * 3));   // distance up to ceiling
    cur_req = "R10"; hit(41'd125, 0); hit(41'd124, 0); hit(41'd200, 0);
    cur_req = "R7"; step(0, '0, 0, 0, '0, 0, 1, 1);    // stored as 3
    hit(41'd126, 0);
    step(0, '0, 0, 0, '0, 0, 1, 31);                   // stored as 24
    hit(41'd127, 0); hit(41'd128, 0);
    cur_req = "R8"; miss(41'd129, 1);                  // thread 1, no cross match
    cur_req = "R4"; miss(41'd128, 1);                  // descending in thread 1
    hit(41'd127, 1, 7'h7f);
    cur_req = "R12"; hit(41'd126, 1, 7'h01);
    cur_req = "R9";
    for (int i = 1; i <= 7; i++) miss(41'(i * 1000), 0);
    miss(41'd9000, 0);                                 // evicts tracker 0
    hit(41'd129, 0);                                   // old stream gone
    miss(41'd1001, 0);                                 // tracker 1 advances
    cur_req = "R11";
    step(1, la(41'd5000), 0, 1, la(41'd1002), 0);      // hit discarded
    hit(41'd1002, 0);                                  // still advances
    cur_req = "R2"; hit(41'd1003, 0); miss(41'd77, 1); idle(); idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule